// File: doc/BRIEF.md
# Aligned Sync-Pattern Scanner

This block checks a configuration image for its sync pattern while the image streams through, one byte per accepted beat. A stream opens with a one-cycle `start` pulse, and bytes then arrive under `in_valid`, with `in_last` marking the final byte. The block tells the loader whether the four-byte sync sequence 0x66, 0x55, 0x99, 0xAA appears at a word-aligned offset within the leading window of the image. The default window is 128 bytes.

Only offsets that are multiples of four from the first accepted byte are candidates. A copy of the pattern that straddles a word boundary is rejected. A trailing group of fewer than four bytes is never judged. When the loader is doing a partial reconfiguration, it raises `bypass` with `start`. The scan is then skipped and the image is accepted at once.

`done` marks the end of a scan with a one-cycle pulse. `found` holds the verdict until the next `start`.

Top module: `cfg_sync_scan`

## Requirements
- R1: After reset, `found` and `done` are 0. Bytes offered before the first `start` are ignored and cannot set `found`.
- R2: `found` rises in the cycle after an accepted byte that completes a word whose bytes, at lane 0 through lane 3, are 0x66, 0x55, 0x99, 0xAA. The lane is the accepted-byte index since `start`, taken modulo 4. Any other order, such as 0xAA 0x99 0x55 0x66, does not match.
- R3: A pattern that begins at a lane other than 0 is not a match.
- R4: When the stream ends with a group of fewer than four bytes, that group is never compared, even when it holds a prefix of the pattern.
- R5: If `bypass` is 1 in the `start` cycle, `found` and `done` are both 1 in the next cycle. The bytes of that stream are ignored.
- R6: Once set, `found` stays 1 until a `start`. A `start` without `bypass` clears it in the next cycle.
- R7: `done` is 1 for exactly one cycle: the cycle after the accepted byte that carries `in_last`.
- R8: If `in_last` has not come by then, `done` pulses in the cycle after the WINDOW_BYTES-th accepted byte. Later bytes are ignored, so a pattern at or beyond offset WINDOW_BYTES is not found.
- R9: Cycles with `in_valid` low consume no byte and do not advance the lane.
- R10: In a cycle where `start` is 1, any byte offered under `in_valid` is dropped. The next accepted byte is lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that opens a new stream |
| bypass | input | 1 | Sampled with `start`; accept the image without scanning |
| in_valid | input | 1 | `in_byte` holds a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the stream |
| found | output | 1 | Sync pattern seen (or bypassed); held until next `start` |
| done | output | 1 | One-cycle pulse that ends the scan |

## Verification
Every result of this block comes from a single register stage, so each output is due exactly one cycle after the edge that samples its cause. `found` follows the fourth byte of a matching word. `done` follows the last or window-closing byte, or a bypassed `start`. A `start` clears `found` one cycle later. The bench applies inputs just after a rising edge and steps a behavioural model on that same edge, using a queue of accepted bytes. It compares both outputs with the model at the following falling edge, so every cycle is checked at the moment its result is due. Explicit end-of-stream checks against hand-derived verdicts back up the model.

// File: rtl/sync_scan_pkg.sv
package sync_scan_pkg;

    // Pattern as it appears in the stream: lane 0 in bits [31:24]
    localparam logic [31:0] SYNC_PATTERN = 32'h6655_99AA;
    localparam int          LANES        = 4;

    typedef struct packed {
        logic active;    // stream open and still scanning
        logic found;     // verdict
        logic done;      // end-of-scan pulse
        logic word_ok;   // all bytes of current word matched so far
    } scan_state_t;

endpackage

// File: rtl/sync_lane_cmp.sv
module sync_lane_cmp #(
    parameter logic [31:0] PATTERN = sync_scan_pkg::SYNC_PATTERN,
    parameter int          LANES   = sync_scan_pkg::LANES,
    localparam int         LANE_W  = $clog2(LANES)
) (
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        data,
    output logic              hit
);

    logic [7:0] expect_byte [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign expect_byte[g] = PATTERN[8*(LANES-1-g) +: 8];
    end

    assign hit = (data == expect_byte[lane]);

endmodule

// File: rtl/sync_byte_ctr.sv
module sync_byte_ctr #(
    parameter int  LIMIT = 128,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             at_final
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step && (cnt_q != CNT_W'(LIMIT))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count    = cnt_q;
    assign at_final = (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/cfg_sync_scan.sv
module cfg_sync_scan #(
    parameter int WINDOW_BYTES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       bypass,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_last,
    output logic       found,
    output logic       done
);
    import sync_scan_pkg::*;

    localparam int CNT_W  = $clog2(WINDOW_BYTES + 1);
    localparam int LANE_W = $clog2(LANES);

    scan_state_t st_d, st_q;

    logic [CNT_W-1:0]  byte_cnt;
    logic              cnt_at_final;
    logic [LANE_W-1:0] lane;
    logic              byte_hit;
    logic              accept;
    logic              stream_end;

    assign accept     = st_q.active && in_valid && !start;
    assign lane       = byte_cnt[LANE_W-1:0];
    assign stream_end = accept && (in_last || cnt_at_final);

    sync_byte_ctr #(.LIMIT(WINDOW_BYTES)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .step     (accept),
        .count    (byte_cnt),
        .at_final (cnt_at_final)
    );

    sync_lane_cmp #(.PATTERN(SYNC_PATTERN), .LANES(LANES)) u_cmp (
        .lane (lane),
        .data (in_byte),
        .hit  (byte_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.active  = !bypass;
            st_d.found   = bypass;
            st_d.done    = bypass;
            st_d.word_ok = 1'b1;
        end else if (accept) begin
            if (lane == LANE_W'(LANES - 1)) begin
                if (st_q.word_ok && byte_hit) begin
                    st_d.found = 1'b1;
                end
                st_d.word_ok = 1'b1;
            end else begin
                st_d.word_ok = st_q.word_ok && byte_hit;
            end
            if (stream_end) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, found: 1'b0, done: 1'b0, word_ok: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign found = st_q.found;
    assign done  = st_q.done;

endmodule

// File: rtl/cfg_sync_scan_chk.sv
module cfg_sync_scan_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bypass,
    input logic in_valid,
    input logic found,
    input logic done
);

    // R5
    bypass_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bypass) |=> (found && done));

    // R6
    found_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !bypass) |=> !found);

    // R6
    found_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !start) |=> found);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R1
    found_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> $past(start || in_valid));

    // R9
    idle_no_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !in_valid && !found) |=> !found);

endmodule

bind cfg_sync_scan cfg_sync_scan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bypass   (bypass),
    .in_valid (in_valid),
    .found    (found),
    .done     (done)
);

// File: tb/cfg_sync_scan_tb.sv
`timescale 1ns/100ps
module cfg_sync_scan_tb;

    localparam int WIN = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       bypass = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_last = 1'b0;
    logic       found, done;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    cfg_sync_scan #(.WINDOW_BYTES(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass),
        .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
        .found(found), .done(done)
    );

    // Behavioural reference model
    logic [7:0] seen[$];
    bit m_active = 0, m_found = 0, m_done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen.delete();
            m_active = 0; m_found = 0; m_done = 0;
        end else if (start) begin
            seen.delete();
            m_active = !bypass; m_found = bypass; m_done = bypass;
        end else begin
            m_done = 0;
            if (m_active && in_valid) begin
                seen.push_back(in_byte);
                if (seen.size() % 4 == 0) begin
                    int n;
                    n = seen.size();
                    if (seen[n-4] == 8'h66 && seen[n-3] == 8'h55 &&
                        seen[n-2] == 8'h99 && seen[n-1] == 8'hAA)
                        m_found = 1;
                end
                if (in_last || seen.size() == WIN) begin
                    m_done = 1; m_active = 0;
                end
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check(cur_req, "found vs model", found, m_found);
        check(cur_req, "done vs model", done, m_done);
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic open_stream(input bit bp);
        start = 1; bypass = bp; tick();
        start = 0; bypass = 0;
    endtask

    task automatic feed(input logic [7:0] b[$], input bit mark_last, input bit gaps);
        foreach (b[i]) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid = 0; tick(); tick();
            end
            in_valid = 1; in_byte = b[i];
            in_last  = mark_last && (i == b.size() - 1);
            tick();
        end
        in_valid = 0; in_last = 0; in_byte = 8'h00;
    endtask

    task automatic verdict(input string req, input logic exp);
        tick(); tick();
        #1 check(req, "final verdict", found, exp);
    endtask

    int watchdog = 0;
    always @(posedge clk) begin
        watchdog++;
        if (watchdog > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b[$];
        cur_req = "R1";
        #1 check("R1", "reset found", found, 1'b0);
        check("R1", "reset done", done, 1'b0);
        tick(); tick(); rst_n = 1; tick();
        // R1: bytes before any start
        feed('{8'h66, 8'h55, 8'h99, 8'hAA}, 1, 0);
        verdict("R1", 1'b0);

        cur_req = "R2";
        open_stream(0);
        feed('{8'h00, 8'h00, 8'h00, 8'h00, 8'h66, 8'h55, 8'h99, 8'hAA, 8'h11, 8'h22}, 1, 0);
        verdict("R2", 1'b1);
        open_stream(0);
        feed('{8'hAA, 8'h99, 8'h55, 8'h66, 8'h00, 8'h00, 8'h00, 8'h00}, 1, 0);
        verdict("R2", 1'b0);

        cur_req = "R3";
        open_stream(0);
        feed('{8'h00, 8'h66, 8'h55, 8'h99, 8'hAA, 8'h00, 8'h00, 8'h00}, 1, 0);
        verdict("R3", 1'b0);

        cur_req = "R4";
        open_stream(0);
        feed('{8'h01, 8'h02, 8'h03, 8'h04, 8'h66, 8'h55, 8'h99}, 1, 0);
        verdict("R4", 1'b0);

        cur_req = "R5";
        open_stream(1);
        #1 check("R5", "bypass found", found, 1'b1);
        check("R5", "bypass done", done, 1'b1);
        feed('{8'h12, 8'h34, 8'h56, 8'h78}, 1, 0);
        verdict("R5", 1'b1);

        cur_req = "R6";
        open_stream(0);
        feed('{8'h66, 8'h55, 8'h99, 8'hAA, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1, 0);
        verdict("R6", 1'b1);
        open_stream(0);
        #1 check("R6", "cleared by start", found, 1'b0);
        feed('{8'h00, 8'h11, 8'h22, 8'h33}, 1, 0);
        verdict("R6", 1'b0);

        cur_req = "R7";
        open_stream(0);
        feed('{8'h66, 8'h55, 8'h99, 8'hAA}, 1, 0);
        #1 check("R7", "done after last", done, 1'b1);
        tick();
        check("R7", "done one cycle", done, 1'b0);

        cur_req = "R8";
        b.delete();
        for (int i = 0; i < 140; i++) b.push_back(8'h00);
        b[128] = 8'h66; b[129] = 8'h55; b[130] = 8'h99; b[131] = 8'hAA;
        open_stream(0);
        feed(b, 1, 0);
        verdict("R8", 1'b0);
        b[124] = 8'h66; b[125] = 8'h55; b[126] = 8'h99; b[127] = 8'hAA;
        b[128] = 8'h00;
        open_stream(0);
        feed(b, 0, 0);
        verdict("R8", 1'b1);

        cur_req = "R9";
        open_stream(0);
        feed('{8'h01, 8'h02, 8'h03, 8'h04, 8'h66, 8'h55, 8'h99, 8'hAA}, 1, 1);
        verdict("R9", 1'b1);

        cur_req = "R10";
        start = 1; in_valid = 1; in_byte = 8'h66; tick();
        start = 0;
        feed('{8'h55, 8'h99, 8'hAA, 8'h66, 8'h55, 8'h99, 8'hAA}, 1, 0);
        verdict("R10", 1'b0);

        tick(); tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule